// File: doc/BRIEF.md
# Share-to-Bank Translation Buffer

This block sits next to a core and turns a last-level-cache request into a physical destination. The request carries the line address of an L1 miss and a share identifier supplied by the TLB. A small fully associative table of translation entries is searched by share identifier. Each entry holds a table of bank/partition slots, and a programmable XOR hash of the line address picks one slot. The chosen slot names the bank and the partition inside that bank where the line lives.

Software loads the slot table so that each bank/partition pair appears a number of times in proportion to the capacity the share holds there. Lines therefore spread across banks in proportion to allocation, and each line has exactly one home. A request whose share is not in the table raises a miss exception in the response. Software then writes the entry through the configuration port, because the buffer never fetches anything itself. A configuration write for a share that is already held replaces that entry in place. A write for a new share replaces a round-robin victim.

Top module: `stb_xlate`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_miss`, `rsp_bank` and `rsp_part` are all zero. No entry is valid, every hash row r holds only bit r set, and the replacement pointer names entry 0.
- R2: `rsp_valid` is high in the cycle after `req_valid` was high and is low in the cycle after `req_valid` was low. In cycles without a request, the other response outputs are zero.
- R3: A request whose share matches no valid entry gives `rsp_miss`=1 with `rsp_bank`=0 and `rsp_part`=0. The entry table is left unchanged.
- R4: A request whose share matches an entry gives `rsp_miss`=0 and returns slot k of that entry. Slot k is bits [8k+7:8k] of `cfg_slots` as written. Its upper 6 bits are the bank and its lower 2 bits are the partition.
- R5: The slot index k has 6 bits. Bit r of k is the XOR reduction of `req_addr` AND hash row r, so with the reset rows k equals `req_addr[5:0]`. A hash write with `hash_row` below 6 replaces that row. A hash write with `hash_row` of 6 or 7 changes nothing.
- R6: A configuration write whose share is held by no valid entry is stored in the entry named by the replacement pointer. The pointer then steps by one modulo 4, so after four new shares a fifth evicts the oldest allocation.
- R7: A configuration write whose share is already held overwrites that entry and leaves the replacement pointer unchanged. At most one entry ever matches a share.
- R8: A request in the same cycle as a configuration or hash write is translated with the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 40 | Line address of the L1 miss |
| req_share | input | 10 | Share identifier from the TLB |
| rsp_valid | output | 1 | Registered response present |
| rsp_miss | output | 1 | No entry held the share (software refill needed) |
| rsp_bank | output | 6 | Destination bank |
| rsp_part | output | 2 | Partition within the bank |
| cfg_we | input | 1 | Write an entry |
| cfg_share | input | 10 | Share identifier of the written entry |
| cfg_slots | input | 512 | 64 slots, slot k in bits [8k+7:8k], bank above partition |
| hash_we | input | 1 | Write one hash row |
| hash_row | input | 3 | Row number, 0 to 5 valid |
| hash_mask | input | 40 | New row contents |

## Verification
The translation result, the miss flag and the valid flag all appear on the rising edge after the request cycle. The bench drives each request just after one edge and reads the response just after the next. Configuration and hash writes also take effect on that edge, so a request issued in the same cycle as a write is compared with a reference model updated only after the check. Random traffic draws from a share pool larger than the entry count, which forces both evictions and in-place overwrites.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int unsigned STB_ENTRIES = 4;
  localparam int unsigned STB_SLOTS   = 64;
  localparam int unsigned STB_BANK_W  = 6;
  localparam int unsigned STB_PART_W  = 2;
  localparam int unsigned STB_ADDR_W  = 40;
  localparam int unsigned STB_SHARE_W = 10;
endpackage

// File: rtl/stb_hash.sv
module stb_hash #(
  parameter int unsigned ADDR_W = stb_pkg::STB_ADDR_W,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ROW_W  = (IDX_W > 1) ? $clog2(IDX_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_we,
  input  logic [ROW_W-1:0]  row_sel,
  input  logic [ADDR_W-1:0] row_mask,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0][ADDR_W-1:0] rows_q;
  logic row_ok;

  function automatic logic [IDX_W-1:0] h3_fold(input logic [ADDR_W-1:0] a,
                                               input logic [IDX_W-1:0][ADDR_W-1:0] m);
    logic [IDX_W-1:0] r;
    for (int b = 0; b < int'(IDX_W); b++) r[b] = ^(a & m[b]);
    return r;
  endfunction

  assign row_ok = row_we && (int'(row_sel) < int'(IDX_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < int'(IDX_W); b++) rows_q[b] <= ADDR_W'(1) << b;
    end else if (row_ok) begin
      rows_q[row_sel] <= row_mask;
    end
  end

  assign idx = h3_fold(addr, rows_q);

  // R5: a row number outside the matrix leaves every row as it was
  a_r5_bad_row_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (row_we && !row_ok) |=> $stable(rows_q));
  // R5: a legal row write lands in the named row
  a_r5_row_written: assert property (@(posedge clk) disable iff (!rst_n)
    row_ok |=> rows_q[$past(row_sel)] == $past(row_mask));
endmodule

// File: rtl/stb_rr_victim.sv
module stb_rr_victim #(
  parameter int unsigned ENTRIES = stb_pkg::STB_ENTRIES,
  parameter int unsigned PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R6: each allocation moves the pointer by exactly one, wrapping after the last entry
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < int'(ENTRIES));
endmodule

// File: rtl/stb_entries.sv
module stb_entries #(
  parameter int unsigned ENTRIES = stb_pkg::STB_ENTRIES,
  parameter int unsigned SLOTS   = stb_pkg::STB_SLOTS,
  parameter int unsigned SLOT_W  = stb_pkg::STB_BANK_W + stb_pkg::STB_PART_W,
  parameter int unsigned SHARE_W = stb_pkg::STB_SHARE_W,
  parameter int unsigned IDX_W   = $clog2(SLOTS),
  parameter int unsigned TBL_W   = SLOTS * SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SHARE_W-1:0] wr_share,
  input  logic [TBL_W-1:0]   wr_slots,
  input  logic [SHARE_W-1:0] lk_share,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic               lk_hit,
  output logic [SLOT_W-1:0]  lk_slot
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]              vld_q;
  logic [ENTRIES-1:0][SHARE_W-1:0] tag_q;
  logic [ENTRIES-1:0][TBL_W-1:0]   tbl_q;
  logic [ENTRIES-1:0]              wr_hit_vec, lk_hit_vec;
  logic                            wr_hit_any, alloc;
  logic [PTR_W-1:0]                victim, wr_tgt;
  logic [TBL_W-1:0]                lk_row;

  function automatic logic [PTR_W-1:0] oh_to_idx(input logic [ENTRIES-1:0] v);
    logic [PTR_W-1:0] r = '0;
    for (int e = 0; e < int'(ENTRIES); e++) if (v[e]) r = PTR_W'(e);
    return r;
  endfunction

  for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_cmp
    assign wr_hit_vec[e] = vld_q[e] && (tag_q[e] == wr_share);
    assign lk_hit_vec[e] = vld_q[e] && (tag_q[e] == lk_share);
  end

  assign wr_hit_any = |wr_hit_vec;
  assign alloc      = wr_en && !wr_hit_any;
  assign wr_tgt     = wr_hit_any ? oh_to_idx(wr_hit_vec) : victim;

  stb_rr_victim #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .step(alloc), .ptr(victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      tag_q <= '0;
      tbl_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_tgt] <= 1'b1;
      tag_q[wr_tgt] <= wr_share;
      tbl_q[wr_tgt] <= wr_slots;
    end
  end

  always_comb begin
    lk_row = '0;
    for (int e = 0; e < int'(ENTRIES); e++)
      if (lk_hit_vec[e]) lk_row = lk_row | tbl_q[e];
  end

  assign lk_hit  = |lk_hit_vec;
  assign lk_slot = lk_row[int'(lk_idx)*SLOT_W +: SLOT_W];

  // R7: no two entries can hold the same share
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec) && $onehot0(wr_hit_vec));
  // R7: rewriting a held share does not consume a victim
  a_r7_overwrite_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit_any) |=> $stable(victim));
  // R6: a new share lands in the entry the pointer named
  a_r6_alloc_target: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> vld_q[$past(victim)] && (tag_q[$past(victim)] == $past(wr_share)));
endmodule

// File: rtl/stb_xlate.sv
module stb_xlate #(
  parameter int unsigned ENTRIES = stb_pkg::STB_ENTRIES,
  parameter int unsigned SLOTS   = stb_pkg::STB_SLOTS,
  parameter int unsigned BANK_W  = stb_pkg::STB_BANK_W,
  parameter int unsigned PART_W  = stb_pkg::STB_PART_W,
  parameter int unsigned ADDR_W  = stb_pkg::STB_ADDR_W,
  parameter int unsigned SHARE_W = stb_pkg::STB_SHARE_W,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned ROW_W  = (IDX_W > 1) ? $clog2(IDX_W) : 1,
  localparam int unsigned SLOT_W = BANK_W + PART_W,
  localparam int unsigned TBL_W  = SLOTS * SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SHARE_W-1:0] req_share,
  output logic               rsp_valid,
  output logic               rsp_miss,
  output logic [BANK_W-1:0]  rsp_bank,
  output logic [PART_W-1:0]  rsp_part,
  input  logic               cfg_we,
  input  logic [SHARE_W-1:0] cfg_share,
  input  logic [TBL_W-1:0]   cfg_slots,
  input  logic               hash_we,
  input  logic [ROW_W-1:0]   hash_row,
  input  logic [ADDR_W-1:0]  hash_mask
);
  logic [IDX_W-1:0]  slot_idx;
  logic              lk_hit;
  logic [SLOT_W-1:0] lk_slot;
  logic              take;

  stb_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_hash (
    .clk(clk), .rst_n(rst_n), .row_we(hash_we), .row_sel(hash_row),
    .row_mask(hash_mask), .addr(req_addr), .idx(slot_idx)
  );

  stb_entries #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .SLOT_W(SLOT_W),
                .SHARE_W(SHARE_W), .IDX_W(IDX_W), .TBL_W(TBL_W)) u_entries (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_share(cfg_share),
    .wr_slots(cfg_slots), .lk_share(req_share), .lk_idx(slot_idx),
    .lk_hit(lk_hit), .lk_slot(lk_slot)
  );

  assign take = req_valid && lk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_bank  <= '0;
      rsp_part  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_miss  <= req_valid && !lk_hit;
      rsp_bank  <= take ? lk_slot[SLOT_W-1:PART_W] : '0;
      rsp_part  <= take ? lk_slot[PART_W-1:0]      : '0;
    end
  end

  // R2: one response for each request, one cycle later
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && rsp_bank == '0 && rsp_part == '0);
  // R3: an exception carries no destination
  a_r3_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_valid && rsp_bank == '0 && rsp_part == '0);
endmodule

// File: tb/stb_xlate_test.sv
module stb_xlate_test;
  localparam int AW = 40;
  localparam int SW = 10;
  localparam int TW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_share = '0;
  logic rsp_valid, rsp_miss;
  logic [5:0] rsp_bank;
  logic [1:0] rsp_part;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_share = '0;
  logic [TW-1:0] cfg_slots = '0;
  logic hash_we = 1'b0;
  logic [2:0] hash_row = '0;
  logic [AW-1:0] hash_mask = '0;

  always #5 clk = ~clk;

  stb_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_share(req_share), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
    .rsp_bank(rsp_bank), .rsp_part(rsp_part), .cfg_we(cfg_we),
    .cfg_share(cfg_share), .cfg_slots(cfg_slots), .hash_we(hash_we),
    .hash_row(hash_row), .hash_mask(hash_mask)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  logic [AW-1:0] m_rows [6];
  bit            m_vld  [4];
  logic [SW-1:0] m_tag  [4];
  logic [TW-1:0] m_tbl  [4];
  int            m_ptr;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] m_idx(input logic [AW-1:0] a);
    logic [5:0] k;
    for (int r = 0; r < 6; r++) begin
      logic p = 1'b0;
      for (int b = 0; b < AW; b++) p = p ^ (a[b] & m_rows[r][b]);
      k[r] = p;
    end
    return k;
  endfunction

  function automatic int m_find(input logic [SW-1:0] s);
    for (int e = 0; e < 4; e++) if (m_vld[e] && m_tag[e] == s) return e;
    return -1;
  endfunction

  task automatic m_write(input logic [SW-1:0] s, input logic [TW-1:0] t);
    int e = m_find(s);
    if (e < 0) begin
      e = m_ptr;
      m_ptr = (m_ptr + 1) % 4;
    end
    m_vld[e] = 1'b1; m_tag[e] = s; m_tbl[e] = t;
  endtask

  function automatic logic [TW-1:0] rand_tbl();
    logic [TW-1:0] t;
    for (int w = 0; w < TW/32; w++) t[w*32 +: 32] = $urandom;
    return t;
  endfunction

  function automatic logic [TW-1:0] ramp_tbl();
    logic [TW-1:0] t;
    for (int k = 0; k < 64; k++) t[k*8 +: 8] = 8'(k * 3 + 1);
    return t;
  endfunction

  // expected response for a request against the current model
  task automatic expect_rsp(input logic [AW-1:0] a, input logic [SW-1:0] s,
                            output bit miss, output logic [5:0] bank, output logic [1:0] part);
    int e = m_find(s);
    if (e < 0) begin
      miss = 1'b1; bank = '0; part = '0;
    end else begin
      logic [7:0] sl = m_tbl[e][int'(m_idx(a))*8 +: 8];
      miss = 1'b0; bank = sl[7:2]; part = sl[1:0];
    end
  endtask

  // request, optionally with a configuration write in the same cycle (R8)
  task automatic lookup(input string req, input logic [AW-1:0] a, input logic [SW-1:0] s,
                        input bit with_cfg, input logic [SW-1:0] cs, input logic [TW-1:0] ct);
    bit em; logic [5:0] eb; logic [1:0] ep;
    expect_rsp(a, s, em, eb, ep);
    req_valid = 1'b1; req_addr = a; req_share = s;
    cfg_we = with_cfg; cfg_share = cs; cfg_slots = ct;
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_we = 1'b0;
    if (with_cfg) m_write(cs, ct);
    chk({req, " valid"}, 64'(rsp_valid), 64'(1));
    chk({req, " miss"},  64'(rsp_miss),  64'(em));
    chk({req, " bank"},  64'(rsp_bank),  64'(eb));
    chk({req, " part"},  64'(rsp_part),  64'(ep));
  endtask

  task automatic cfg_write(input logic [SW-1:0] s, input logic [TW-1:0] t);
    cfg_we = 1'b1; cfg_share = s; cfg_slots = t;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_write(s, t);
  endtask

  task automatic hash_write(input logic [2:0] r, input logic [AW-1:0] m);
    hash_we = 1'b1; hash_row = r; hash_mask = m;
    @(posedge clk); #1;
    hash_we = 1'b0;
    if (r < 6) m_rows[r] = m;
  endtask

  function automatic logic [AW-1:0] rand_addr();
    return {8'($urandom), $urandom};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20130911));
    for (int r = 0; r < 6; r++) m_rows[r] = AW'(1) << r;
    for (int e = 0; e < 4; e++) begin m_vld[e] = 0; m_tag[e] = '0; m_tbl[e] = '0; end
    m_ptr = 0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state of the outputs
    chk("R1 valid", 64'(rsp_valid), 0);
    chk("R1 miss",  64'(rsp_miss),  0);
    chk("R1 bank",  64'(rsp_bank),  0);
    chk("R1 part",  64'(rsp_part),  0);
    @(posedge clk); #1;
    // R2: no request, no response
    chk("R2 idle valid", 64'(rsp_valid), 0);

    // R1/R3: empty table misses
    lookup("R3 empty", 40'h12_3456_789A, 10'd5, 0, '0, '0);

    // R4/R5: ramp table with reset hash rows
    cfg_write(10'd5, ramp_tbl());
    for (int k = 0; k < 64; k += 9)
      lookup("R5 reset rows", {rand_addr()} & ~40'h3F | 40'(k), 10'd5, 0, '0, '0);
    lookup("R4 slot63", 40'hFF_FFFF_FFFF, 10'd5, 0, '0, '0);

    // R6: four allocations wrap the pointer, fifth evicts share 5
    cfg_write(10'd6, rand_tbl());
    cfg_write(10'd7, rand_tbl());
    cfg_write(10'd8, rand_tbl());
    cfg_write(10'd9, rand_tbl());
    lookup("R6 evicted", 40'h0, 10'd5, 0, '0, '0);
    lookup("R6 kept", 40'h1234, 10'd6, 0, '0, '0);
    // R7: overwrite share 7 must not evict share 6 (pointer on it)
    cfg_write(10'd7, rand_tbl());
    lookup("R7 overwrite data", 40'h55AA, 10'd7, 0, '0, '0);
    lookup("R7 no evict", 40'h77, 10'd6, 0, '0, '0);
    cfg_write(10'd10, rand_tbl());
    lookup("R6 next victim", 40'h77, 10'd6, 0, '0, '0);
    lookup("R7 still held", 40'h99, 10'd7, 0, '0, '0);

    // R5: programmed rows and an out-of-range row write
    for (int r = 0; r < 6; r++) hash_write(3'(r), rand_addr());
    hash_write(3'd6, '1);
    hash_write(3'd7, 40'hA5_A5A5_A5A5);
    for (int i = 0; i < 8; i++) lookup("R5 programmed rows", rand_addr(), 10'd9, 0, '0, '0);

    // R8: write in the same cycle as a request on that share
    lookup("R8 same cycle new", 40'h3C, 10'd11, 1, 10'd11, rand_tbl());
    lookup("R8 after write", 40'h3C, 10'd11, 0, '0, '0);
    lookup("R8 same cycle overwrite", 40'hC3, 10'd11, 1, 10'd11, rand_tbl());
    lookup("R8 after overwrite", 40'hC3, 10'd11, 0, '0, '0);

    // random mix over a share pool larger than the table
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 99);
      logic [SW-1:0] s = SW'($urandom_range(20, 25));
      if (op < 18) cfg_write(s, rand_tbl());
      else if (op < 26) hash_write(3'($urandom_range(0, 7)), rand_addr());
      else if (op < 34) lookup("R8 random", rand_addr(), s, 1,
                               SW'($urandom_range(20, 25)), rand_tbl());
      else lookup("R4 random", rand_addr(), s, 0, '0, '0);
      if (op % 7 == 0) begin
        @(posedge clk); #1;
        chk("R2 gap valid", 64'(rsp_valid), 0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule